// File: doc/BRIEF.md
# Duplicated Command Register with Parity Check

This block sits between a memory controller and a set of DRAM devices. On each rising clock edge it captures a 28-bit address/command word and presents it on two output copies that always carry the same value, so that each copy can drive half of the device load. A parity bit sent by the controller with each word is checked, and a mismatch is reported on an active-low error flag. The flag appears one cycle after the word reaches the outputs.

Two active-low chip selects can freeze the outputs. When gating is enabled and both selects are high, the outputs keep their last value and no parity check is made. An asynchronous active-low reset overrides everything else. It clears the data outputs to zero and drives the error flag to its inactive (high) level.

Top module: `cmd_regbuf`

## Requirements
- R1: On a rising clock edge where an update is allowed, both output copies take the value on `d_i`, and they keep it until the next updating edge.
- R2: `qa_o` and `qb_o` are equal in every cycle.
- R3: While `rst_ni` is low, `qa_o` and `qb_o` are all zeros and `perr_no` is 1.
- R4: Reset takes effect without a clock edge and overrides the chip-select gating.
- R5: With `gate_en_i` = 1, an edge where `cs0_ni` = 1 and `cs1_ni` = 1 leaves the outputs unchanged. An edge where either select is 0 updates them.
- R6: With `gate_en_i` = 0, every edge updates the outputs, whatever the chip selects are.
- R7: Parity is odd over the 29 bits {`d_i`, `par_i`}, so a word is in error when the XOR of those bits is 0. For an erroneous word captured at edge N, `perr_no` is 0 from edge N+1 until edge N+2. A correct word gives `perr_no` = 1 over that same interval.
- R8: An edge where the outputs are held makes no parity check. `perr_no` is 1 after the following edge, whatever `par_i` was.
- R9: After reset is released, while `d_i` stays zero the outputs stay zero on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d_i | input | 28 | Address/command word from the controller |
| par_i | input | 1 | Parity bit sent with `d_i` |
| cs0_ni | input | 1 | Chip select 0, active low |
| cs1_ni | input | 1 | Chip select 1, active low |
| gate_en_i | input | 1 | 1 enables hold-on-both-selects-high gating |
| qa_o | output | 28 | Registered word, copy A |
| qb_o | output | 28 | Registered word, copy B |
| perr_no | output | 1 | Parity error flag, active low, registered |

## Verification
The assertions check in every cycle that the two copies agree, that an updating edge loads the input word, and that a held edge keeps the outputs. They also check that the error flag follows a bad word after two edges and stays high after a held edge, and that the outputs are zero and the flag high during reset. Some behaviour can only be shown by the bench's scenarios. These are a reset asserted between clock edges and seen before any edge, reset winning over active gating, outputs that stay zero with quiet inputs after release, and the full mix of random words, parity bits and select patterns compared against a cycle model.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;
  localparam int unsigned CMD_W = 28;

  // odd parity over data plus parity bit; returns 1 on a bad word
  function automatic logic par_bad(input logic [CMD_W-1:0] d, input logic p);
    return ~(^{d, p});
  endfunction
endpackage

// File: rtl/cmd_gate.sv
module cmd_gate (
  input  logic cs0_ni,
  input  logic cs1_ni,
  input  logic gate_en_i,
  output logic upd_o
);
  assign upd_o = ~gate_en_i | ~cs0_ni | ~cs1_ni;
endmodule

// File: rtl/cmd_copy_reg.sv
module cmd_copy_reg #(
  parameter int unsigned W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= d_i;
  end
endmodule

// File: rtl/cmd_par_chk.sv
module cmd_par_chk
  import cmd_regbuf_pkg::*;
#(
  parameter int unsigned W = CMD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] d_i,
  input  logic         par_i,
  output logic         perr_no
);
  logic pe_q;
  logic bad;

  assign bad = ~(^{d_i, par_i});

  // stage 1 aligns with the data capture, stage 2 drives the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_q    <= 1'b0;
      perr_no <= 1'b1;
    end else begin
      pe_q    <= upd_i & bad;
      perr_no <= ~pe_q;
    end
  end
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
#(
  parameter int unsigned W     = CMD_W,
  parameter int unsigned NCOPY = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         par_i,
  input  logic         cs0_ni,
  input  logic         cs1_ni,
  input  logic         gate_en_i,
  output logic [W-1:0] qa_o,
  output logic [W-1:0] qb_o,
  output logic         perr_no
);
  logic         upd;
  logic [W-1:0] q_copy [NCOPY];

  cmd_gate u_gate (
    .cs0_ni   (cs0_ni),
    .cs1_ni   (cs1_ni),
    .gate_en_i(gate_en_i),
    .upd_o    (upd)
  );

  // separate flop banks per copy to split the output load
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    cmd_copy_reg #(.W(W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .upd_i (upd),
      .d_i   (d_i),
      .q_o   (q_copy[c])
    );
  end

  assign qa_o = q_copy[0];
  assign qb_o = q_copy[NCOPY-1];

  cmd_par_chk #(.W(W)) u_par (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .d_i    (d_i),
    .par_i  (par_i),
    .perr_no(perr_no)
  );
endmodule

// File: rtl/cmd_regbuf_chk.sv
module cmd_regbuf_chk #(
  parameter int unsigned W = 28
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] d_i,
  input logic         par_i,
  input logic         cs0_ni,
  input logic         cs1_ni,
  input logic         gate_en_i,
  input logic [W-1:0] qa_o,
  input logic [W-1:0] qb_o,
  input logic         perr_no
);
  logic upd_m;
  logic bad_m;
  assign upd_m = !gate_en_i || !cs0_ni || !cs1_ni;
  assign bad_m = ~(^{d_i, par_i});

  AST_COPY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qa_o == qb_o);  // R2

  AST_UPDATE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_m |=> (qa_o == $past(d_i)));  // R1

  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_i && cs0_ni && cs1_ni) |=> $stable(qa_o));  // R5

  AST_UNGATED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |=> (qb_o == $past(d_i)));  // R6

  AST_PERR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_m && bad_m) |-> ##2 !perr_no);  // R7

  AST_PERR_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_m && !bad_m) |-> ##2 perr_no);  // R7

  AST_HELD_NO_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_m |-> ##2 perr_no);  // R8

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (qa_o == '0 && qb_o == '0 && perr_no));  // R3
endmodule

bind cmd_regbuf cmd_regbuf_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .d_i      (d_i),
  .par_i    (par_i),
  .cs0_ni   (cs0_ni),
  .cs1_ni   (cs1_ni),
  .gate_en_i(gate_en_i),
  .qa_o     (qa_o),
  .qb_o     (qb_o),
  .perr_no  (perr_no)
);

// File: tb/cmd_regbuf_tb_top.sv
`timescale 1ns/1ps
module cmd_regbuf_tb_top;
  localparam int W = 28;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] d_i = '0;
  logic         par_i = 1'b0;
  logic         cs0_ni = 1'b1;
  logic         cs1_ni = 1'b1;
  logic         gate_en_i = 1'b1;
  logic [W-1:0] qa_o, qb_o;
  logic         perr_no;

  int n_run = 0;
  int n_fail = 0;

  logic [W-1:0] m_q;
  logic         m_pe;
  logic         m_perr;

  always #2.5 clk_i = ~clk_i;

  cmd_regbuf dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(d_i), .par_i(par_i),
    .cs0_ni(cs0_ni), .cs1_ni(cs1_ni), .gate_en_i(gate_en_i),
    .qa_o(qa_o), .qb_o(qb_o), .perr_no(perr_no)
  );

  function automatic logic f_upd(logic g, logic c0, logic c1);
    return !g || !c0 || !c1;
  endfunction

  function automatic logic f_bad(logic [W-1:0] d, logic p);
    return (^{d, p}) == 1'b0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_q = '0; m_pe = 1'b0; m_perr = 1'b1;
  endtask

  // one clock: model the edge, then check at the following falling edge
  task automatic step(string req);
    logic u;
    @(posedge clk_i);
    u = f_upd(gate_en_i, cs0_ni, cs1_ni);
    m_perr = ~m_pe;
    m_pe = u && f_bad(d_i, par_i);
    if (u) m_q = d_i;
    @(negedge clk_i);
    chk({req, " qa"}, 64'(qa_o), 64'(m_q));
    chk("R2 copy", 64'(qb_o), 64'(qa_o));
    chk({req, " perr"}, 64'(perr_no), 64'(m_perr));
  endtask

  task automatic drive(logic [W-1:0] d, logic p, logic c0, logic c1, logic g);
    d_i = d; par_i = p; cs0_ni = c0; cs1_ni = c1; gate_en_i = g;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R3 qa reset", 64'(qa_o), 64'h0);
    chk("R3 qb reset", 64'(qb_o), 64'h0);
    chk("R3 perr reset", 64'(perr_no), 64'h1);

    // R9: quiet inputs after release keep outputs at zero
    drive('0, 1'b1, 1'b0, 1'b0, 1'b1);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) step("R9");

    // R7: directed bad parity, one-cycle flag
    drive(28'h0000001, 1'b1, 1'b0, 1'b1, 1'b1);
    step("R7 capture");
    drive(28'h0000003, 1'b1, 1'b0, 1'b1, 1'b1);
    step("R7 flag");
    chk("R7 flag low", 64'(perr_no), 64'h0);
    step("R7 release");
    chk("R7 flag high", 64'(perr_no), 64'h1);

    // R5: both selects high hold, bad parity not checked (R8)
    drive(28'hABCDEF1, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R5 load");
    drive(28'h1234567, 1'b1, 1'b1, 1'b1, 1'b1);
    step("R5 hold");
    chk("R5 held value", 64'(qa_o), 64'h0ABCDEF1);
    step("R8 no check");
    chk("R8 perr high", 64'(perr_no), 64'h1);

    // R6: gating disabled, selects high still update
    drive(28'h5A5A5A5, 1'b0, 1'b1, 1'b1, 1'b0);
    step("R6 update");
    chk("R6 value", 64'(qb_o), 64'h5A5A5A5);

    // R1/R5/R6/R7/R8: random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(W'($urandom), r[0], r[1], r[2], r[3] | r[4]);
      step("R1 random");
    end

    // R4: async reset between edges, gating active
    drive(28'hFFFFFFF, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R4 async qa", 64'(qa_o), 64'h0);
    chk("R4 async perr", 64'(perr_no), 64'h1);
    m_reset();
    @(negedge clk_i);
    chk("R4 held in reset", 64'(qb_o), 64'h0);
    drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) step("R9 second release");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule